// File: doc/BRIEF.md
# Soft Reset Sequencer with Cause Register

This block runs the soft-reset sequence of a processor subsystem. A request from inside the chip makes it pull the soft-reset line for a fixed hold time. When that hold ends it captures the debug-port configuration inputs. It then lets go of the line and waits a short settling time. At the end of the settling time it emits one pulse that either starts normal execution from the reset vector or enters debug mode.

A request arriving from outside on the external soft-reset pin uses the same sequence without the internal hold. The configuration is captured as soon as the pin is seen asserted. If the external pin is still asserted when the settling time ends, the decision waits until the pin is released.

The block also holds a 32-bit cause register. Its flags are numbered from the most significant bit downward. A flag is set by a hardware cause input and is cleared by writing a one to its position. Any bit outside the eight flags reads as zero.

Top module: `softrst_seq_top`

## Requirements
- R1: One cycle after `int_req_i` is sampled high, `soft_rst_drive_o` is high. With no new request, it stays high for exactly HOLD_CYC (default 512) cycles and then goes low.
- R2: `debug_mode_cfg_o` takes the value of `cfg_sel_i` sampled on the edge that ends the internal hold, or on the edge where the external pin is first seen high in idle. It keeps that value until the next capture.
- R3: After the line is released, no decision pulse appears for SETTLE_CYC-1 (default 15) cycles. The pulse is registered on the SETTLE_CYC-th edge after release, and it is never high while `soft_rst_drive_o` is high.
- R4: If `ext_pin_i` is high on the edge that ends the settling wait, no pulse is issued. The pulse is issued on the first later edge where `ext_pin_i` is low.
- R5: At the decision, `dbg_clk_i` high gives a one-cycle `enter_debug_o` pulse and `dbg_clk_i` low gives a one-cycle `start_normal_o` pulse. The two pulses are never high together.
- R6: `ext_pin_i` seen high in idle sets flag 1 (status bit 30) and starts the settling wait. `soft_rst_drive_o` stays low.
- R7: `int_req_i` seen high at any point of a running sequence restarts the hold from its full length.
- R8: After `rst`, `status_o` equals 32'hC000_0000, which is flags 0 and 1 set. Bits 23..0 read zero at all times.
- R9: A write with `wr_en_i` high clears each flag k whose bit `wr_data_i[31-k]` is one. Zero bits and bits 23..0 of the write data leave the register unchanged.
- R10: `cause_set_i[k]` high sets flag k (status bit 31-k) on the next edge. A set wins over a clearing write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| int_req_i | input | 1 | Internal soft-reset request |
| ext_pin_i | input | 1 | External soft-reset pin level, 1 = asserted |
| cfg_sel_i | input | 1 | Debug-port clocking-mode select, captured at sampling |
| dbg_clk_i | input | 1 | Debug entry select, read at the decision |
| cause_set_i | input | 8 | Cause set strobes; bit k sets flag k |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | 32 | Status write data, ones clear |
| soft_rst_drive_o | output | 1 | Drive enable for the soft-reset line |
| start_normal_o | output | 1 | One-cycle normal-start pulse |
| enter_debug_o | output | 1 | One-cycle debug-entry pulse |
| debug_mode_cfg_o | output | 1 | Captured clocking-mode select |
| status_o | output | 32 | Cause register, flag k at bit 31-k |

## Verification
The assertions assume that `int_req_i` is the only source that can restart the hold. They also assume that a cause strobe and a clearing write for the same flag may coincide, and they allow for that case. The stimulus raises every request at a falling edge and keeps it for a single cycle. The external pin is released before a new sequence starts, so every run reaches a decision that the bench can predict. The bench covers all four combinations of the two configuration inputs for each request source. It also sweeps every flag through set, ignored write, and clear.

// File: rtl/softrst_pkg.sv
package softrst_pkg;
  localparam int STATUS_W     = 32;
  localparam int NUM_CAUSES   = 8;
  localparam int EXT_SOFT_IDX = 1;

  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_HOLD    = 2'd1,
    SQ_SETTLE  = 2'd2,
    SQ_PINWAIT = 2'd3
  } sq_state_e;
endpackage

// File: rtl/softrst_timer.sv
module softrst_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load_i)
      cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/softrst_fsm.sv
module softrst_fsm
  import softrst_pkg::*;
#(
  parameter int HOLD_CYC   = 512,
  parameter int SETTLE_CYC = 16,
  parameter int CNT_W      = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             int_req_i,
  input  logic             ext_pin_i,
  input  logic             cfg_sel_i,
  input  logic             dbg_clk_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             tmr_dec_o,
  output logic             drive_o,
  output logic             start_normal_o,
  output logic             enter_debug_o,
  output logic             cfg_o,
  output logic             ext_start_o
);
  localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);

  sq_state_e st_q, st_d;
  logic drive_d, sn_d, ed_d, cfg_d;

  always_comb begin
    st_d        = st_q;
    tmr_load_o  = 1'b0;
    tmr_val_o   = '0;
    tmr_dec_o   = 1'b0;
    drive_d     = drive_o;
    sn_d        = 1'b0;
    ed_d        = 1'b0;
    cfg_d       = cfg_o;
    ext_start_o = 1'b0;
    if (int_req_i) begin
      st_d       = SQ_HOLD;
      tmr_load_o = 1'b1;
      tmr_val_o  = HOLD_LD;
      drive_d    = 1'b1;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (ext_pin_i) begin
            st_d        = SQ_SETTLE;
            tmr_load_o  = 1'b1;
            tmr_val_o   = SETTLE_LD;
            cfg_d       = cfg_sel_i;
            ext_start_o = 1'b1;
          end
        end
        SQ_HOLD: begin
          if (tmr_zero_i) begin
            st_d       = SQ_SETTLE;
            tmr_load_o = 1'b1;
            tmr_val_o  = SETTLE_LD;
            cfg_d      = cfg_sel_i;
            drive_d    = 1'b0;
          end else begin
            tmr_dec_o = 1'b1;
          end
        end
        SQ_SETTLE: begin
          if (!tmr_zero_i) begin
            tmr_dec_o = 1'b1;
          end else if (ext_pin_i) begin
            st_d = SQ_PINWAIT;
          end else begin
            st_d = SQ_IDLE;
            ed_d = dbg_clk_i;
            sn_d = !dbg_clk_i;
          end
        end
        default: begin
          if (!ext_pin_i) begin
            st_d = SQ_IDLE;
            ed_d = dbg_clk_i;
            sn_d = !dbg_clk_i;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q           <= SQ_IDLE;
      drive_o        <= 1'b0;
      start_normal_o <= 1'b0;
      enter_debug_o  <= 1'b0;
      cfg_o          <= 1'b0;
    end else begin
      st_q           <= st_d;
      drive_o        <= drive_d;
      start_normal_o <= sn_d;
      enter_debug_o  <= ed_d;
      cfg_o          <= cfg_d;
    end
  end
endmodule

// File: rtl/softrst_status.sv
module softrst_status #(
  parameter int              STATUS_W    = 32,
  parameter int              NUM_CAUSES  = 8,
  parameter logic [NUM_CAUSES-1:0] RESET_FLAGS = 8'b0000_0011
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_CAUSES-1:0] set_i,
  input  logic                  wr_en_i,
  input  logic [STATUS_W-1:0]   wr_data_i,
  output logic [STATUS_W-1:0]   status_o
);
  logic [NUM_CAUSES-1:0] flag_q;

  for (genvar k = 0; k < NUM_CAUSES; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flag_q[k] <= RESET_FLAGS[k];
      else if (set_i[k])
        flag_q[k] <= 1'b1;
      else if (wr_en_i && wr_data_i[STATUS_W-1-k])
        flag_q[k] <= 1'b0;
    end
  end

  always_comb begin
    status_o = '0;
    for (int k = 0; k < NUM_CAUSES; k++)
      status_o[STATUS_W-1-k] = flag_q[k];
  end
endmodule

// File: rtl/softrst_seq_top.sv
module softrst_seq_top
  import softrst_pkg::*;
#(
  parameter int HOLD_CYC   = 512,
  parameter int SETTLE_CYC = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  int_req_i,
  input  logic                  ext_pin_i,
  input  logic                  cfg_sel_i,
  input  logic                  dbg_clk_i,
  input  logic [NUM_CAUSES-1:0] cause_set_i,
  input  logic                  wr_en_i,
  input  logic [STATUS_W-1:0]   wr_data_i,
  output logic                  soft_rst_drive_o,
  output logic                  start_normal_o,
  output logic                  enter_debug_o,
  output logic                  debug_mode_cfg_o,
  output logic [STATUS_W-1:0]   status_o
);
  localparam int MAX_CYC = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
  localparam int CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;

  logic             tmr_load, tmr_dec, tmr_zero, ext_start;
  logic [CNT_W-1:0] tmr_val;
  logic [NUM_CAUSES-1:0] set_vec;

  softrst_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .dec_i     (tmr_dec),
    .zero_o    (tmr_zero)
  );

  softrst_fsm #(
    .HOLD_CYC  (HOLD_CYC),
    .SETTLE_CYC(SETTLE_CYC),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .int_req_i     (int_req_i),
    .ext_pin_i     (ext_pin_i),
    .cfg_sel_i     (cfg_sel_i),
    .dbg_clk_i     (dbg_clk_i),
    .tmr_zero_i    (tmr_zero),
    .tmr_load_o    (tmr_load),
    .tmr_val_o     (tmr_val),
    .tmr_dec_o     (tmr_dec),
    .drive_o       (soft_rst_drive_o),
    .start_normal_o(start_normal_o),
    .enter_debug_o (enter_debug_o),
    .cfg_o         (debug_mode_cfg_o),
    .ext_start_o   (ext_start)
  );

  always_comb begin
    set_vec = cause_set_i;
    set_vec[EXT_SOFT_IDX] = cause_set_i[EXT_SOFT_IDX] | ext_start;
  end

  softrst_status #(
    .STATUS_W  (STATUS_W),
    .NUM_CAUSES(NUM_CAUSES)
  ) u_status (
    .clk      (clk),
    .rst      (rst),
    .set_i    (set_vec),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .status_o (status_o)
  );
endmodule

// File: rtl/softrst_seq_chk.sv
module softrst_seq_chk #(
  parameter int HOLD_CYC   = 512,
  parameter int STATUS_W   = 32,
  parameter int NUM_CAUSES = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  int_req_i,
  input logic [NUM_CAUSES-1:0] cause_set_i,
  input logic                  wr_en_i,
  input logic [STATUS_W-1:0]   wr_data_i,
  input logic                  soft_rst_drive_o,
  input logic                  start_normal_o,
  input logic                  enter_debug_o,
  input logic [STATUS_W-1:0]   status_o
);
  localparam int RW = $clog2(HOLD_CYC) + 2;
  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || int_req_i || !soft_rst_drive_o)
      run_cnt <= '0;
    else
      run_cnt <= run_cnt + 1'b1;
  end

  assert_drive_on_req_R1: assert property (@(posedge clk) disable iff (rst)
    int_req_i |=> soft_rst_drive_o);

  assert_hold_bound_R1: assert property (@(posedge clk) disable iff (rst)
    soft_rst_drive_o |-> (run_cnt < RW'(HOLD_CYC)));

  assert_no_pulse_in_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (start_normal_o || enter_debug_o) |-> !soft_rst_drive_o);

  assert_pulse_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(start_normal_o && enter_debug_o));

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
    (start_normal_o || enter_debug_o) |=> !(start_normal_o || enter_debug_o));

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (rst)
    status_o[STATUS_W-NUM_CAUSES-1:0] == '0);

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_data_i[STATUS_W-1] && !cause_set_i[0]) |=> !status_o[STATUS_W-1]);

  assert_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (status_o[STATUS_W-1] && !(wr_en_i && wr_data_i[STATUS_W-1])) |=> status_o[STATUS_W-1]);

  assert_set_R10: assert property (@(posedge clk) disable iff (rst)
    cause_set_i[0] |=> status_o[STATUS_W-1]);
endmodule

bind softrst_seq_top softrst_seq_chk #(
  .HOLD_CYC(HOLD_CYC)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .int_req_i       (int_req_i),
  .cause_set_i     (cause_set_i),
  .wr_en_i         (wr_en_i),
  .wr_data_i       (wr_data_i),
  .soft_rst_drive_o(soft_rst_drive_o),
  .start_normal_o  (start_normal_o),
  .enter_debug_o   (enter_debug_o),
  .status_o        (status_o)
);

// File: tb/softrst_seq_top_tb.sv
`timescale 1ns/1ps
module softrst_seq_top_tb;
  localparam int HOLD = 512;
  localparam int SETL = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic int_req = 1'b0, ext_pin = 1'b0, cfg_sel = 1'b0, dbg_clk = 1'b0;
  logic [7:0]  cause_set = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        drive, sn, ed, cfg;
  logic [31:0] status;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  softrst_seq_top #(.HOLD_CYC(HOLD), .SETTLE_CYC(SETL)) u_dut (
    .clk(clk), .rst(rst), .int_req_i(int_req), .ext_pin_i(ext_pin),
    .cfg_sel_i(cfg_sel), .dbg_clk_i(dbg_clk), .cause_set_i(cause_set),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .soft_rst_drive_o(drive),
    .start_normal_o(sn), .enter_debug_o(ed), .debug_mode_cfg_o(cfg),
    .status_o(status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
    step(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic run_int(input logic cv, input logic dv);
    cfg_sel = !cv; dbg_clk = !dv;
    int_req = 1'b1;
    step(1);
    int_req = 1'b0;
    chk("R1 drive after request", {31'd0, drive}, 32'd1);
    step(HOLD - 1);
    chk("R1 drive at last hold cycle", {31'd0, drive}, 32'd1);
    cfg_sel = cv; dbg_clk = dv;
    step(1);
    chk("R1 drive released", {31'd0, drive}, 32'd0);
    chk("R2 cfg captured at hold end", {31'd0, cfg}, {31'd0, cv});
    cfg_sel = !cv;
    step(SETL - 1);
    chk("R3 no pulse during settle", {30'd0, sn, ed}, 32'd0);
    step(1);
    chk("R5 decision pulse", {30'd0, sn, ed}, dv ? 32'd1 : 32'd2);
    step(1);
    chk("R5 pulse lasts one cycle", {30'd0, sn, ed}, 32'd0);
    chk("R2 cfg held", {31'd0, cfg}, {31'd0, cv});
  endtask

  task automatic run_ext(input logic cv, input logic dv, input int extra);
    clear_all();
    cfg_sel = cv; dbg_clk = dv; ext_pin = 1'b1;
    step(1);
    cfg_sel = !cv;
    if (extra == 0) ext_pin = 1'b0;
    chk("R6 no drive on external request", {31'd0, drive}, 32'd0);
    chk("R6 external flag set", status, 32'h4000_0000);
    chk("R2 cfg captured on pin", {31'd0, cfg}, {31'd0, cv});
    step(SETL - 1);
    chk("R3 no pulse during settle (ext)", {30'd0, sn, ed}, 32'd0);
    if (extra > 0) begin
      step(1);
      chk("R4 held pin blocks decision", {30'd0, sn, ed}, 32'd0);
      step(extra);
      chk("R4 still waiting on pin", {30'd0, sn, ed}, 32'd0);
      ext_pin = 1'b0;
    end
    step(1);
    chk("R5 decision pulse (ext)", {30'd0, sn, ed}, dv ? 32'd1 : 32'd2);
    step(1);
    chk("R5 pulse ends (ext)", {30'd0, sn, ed}, 32'd0);
  endtask

  initial begin
    step(4);
    rst = 1'b0;
    step(1);
    chk("R8 reset status", status, 32'hC000_0000);
    chk("R8 reset outputs", {28'd0, drive, sn, ed, cfg}, 32'd0);

    for (int m = 0; m < 4; m++) run_int(m[1], m[0]);
    for (int m = 0; m < 4; m++) run_ext(m[1], m[0], 0);
    run_ext(1'b1, 1'b0, 6);
    run_ext(1'b0, 1'b1, 2);

    // R7 restart mid-hold
    dbg_clk = 1'b0; cfg_sel = 1'b0;
    int_req = 1'b1; step(1); int_req = 1'b0;
    step(299);
    int_req = 1'b1; step(1); int_req = 1'b0;
    chk("R7 drive after restart", {31'd0, drive}, 32'd1);
    step(HOLD - 1);
    chk("R7 full hold after restart", {31'd0, drive}, 32'd1);
    step(1);
    chk("R7 release after full hold", {31'd0, drive}, 32'd0);
    step(SETL);
    chk("R7 sequence completes", {30'd0, sn, ed}, 32'd2);
    step(1);

    // status sweep
    clear_all();
    chk("R9 all cleared", status, 32'd0);
    for (int k = 0; k < 8; k++) begin
      cause_set = 8'd1 << k; step(1); cause_set = '0;
      chk("R10 flag set", status, 32'h8000_0000 >> k);
      wr_en = 1'b1; wr_data = ~(32'h8000_0000 >> k) & 32'hFF00_0000; step(1);
      chk("R9 other ones leave flag", status, 32'h8000_0000 >> k);
      wr_data = 32'h0000_0000; step(1);
      chk("R9 zero write no effect", status, 32'h8000_0000 >> k);
      wr_data = 32'h00FF_FFFF; step(1);
      chk("R9 reserved write no effect", status, 32'h8000_0000 >> k);
      wr_data = 32'h8000_0000 >> k; cause_set = 8'd1 << k; step(1);
      cause_set = '0;
      chk("R10 set wins over clear", status, 32'h8000_0000 >> k);
      step(1);
      chk("R9 write one clears", status, 32'd0);
      wr_en = 1'b0; wr_data = '0;
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule